// File: doc/BRIEF.md
# Eight-Stage Parallel/Serial Shift Register

This block holds eight single-bit stages in a chain. It turns a parallel word into a serial stream, and it can also act as a short serial delay line or data queue. A mode input picks the behaviour. With the mode low, every rising clock edge pushes the chain one place toward the far end and takes a new bit from the serial input. With the mode high, the stages are loaded from the eight parallel inputs.

Only the three stages at the far end are brought out as outputs. The five near stages cannot be seen from outside.

A build-time parameter chooses how the parallel load behaves.
- In the clocked style, the load waits for a rising edge.
- In the transparent style, the stages follow the parallel inputs as soon as the mode goes high, and they keep following while it stays high. When the mode drops, the last value is frozen until the next edge shifts it.

There is no reset. The contents are held for as long as no edge arrives, however long the clock is stopped.

Top module: `par_ser_shifter`

## Requirements
- R1: The chain has eight stages, numbered 1 to 8.
  - `parallelIn[0]` loads stage 1 and `parallelIn[7]` loads stage 8.
  - The outputs `tapStage6`, `tapStage7` and `tapStage8` show stages 6, 7 and 8.
- R2: With `loadSel` low, each rising edge of `clk` moves every stage one place toward stage 8 and stores `serialIn` in stage 1.
- R3: A bit sampled from `serialIn` on an edge appears on `tapStage6` on the sixth edge, counting that sampling edge as the first. It appears on `tapStage7` on the seventh edge and on `tapStage8` on the eighth. Before that edge each output still shows the older bits.
- R4: With `ASYNC_LOAD`=0 and `loadSel` high:
  - each rising edge copies `parallelIn` into all stages, and `serialIn` has no effect;
  - between edges, changes on `parallelIn` do not reach the outputs.
- R5: With `ASYNC_LOAD`=1 and `loadSel` high, the outputs follow `parallelIn[7:5]` with no clock edge, and keep following every change while `loadSel` stays high.
- R6: While no rising edge occurs and `loadSel` is low, changes on `serialIn` and `parallelIn` leave the outputs unchanged, for any length of time.
- R7: With `ASYNC_LOAD`=1, once `loadSel` falls, the last parallel value is held, whatever `parallelIn` then does. The next rising edge shifts that held value by one place.
- R8: With `loadSel` low, the two load styles behave identically on every clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift and clocked-load clock, rising edge |
| serialIn | input | 1 | Bit stored in stage 1 on a shift |
| loadSel | input | 1 | High selects parallel load, low selects shift |
| parallelIn | input | 8 | Parallel word; bit 0 goes to stage 1, bit 7 to stage 8 |
| tapStage6 | output | 1 | Content of stage 6 |
| tapStage7 | output | 1 | Content of stage 7 |
| tapStage8 | output | 1 | Content of stage 8 |

## Verification
The bench walks a single one-bit through a zeroed chain and checks the outputs on every edge.
- A design off by one edge, or with a stage missing, shows the bit on the wrong edge.
- Reversed parallel bit order shows up as wrong bits on the outputs while a loaded word drains out.

It puts one version of each style side by side.
- A clocked load that leaked through without an edge, or a transparent load that waited for one, makes the two versions disagree.
- A transparent version that dropped its held word when the mode fell, or that stayed transparent after the fall, reports a changed word before the next edge.
- Stopped-clock windows with busy inputs catch any stage that reacts without an edge.

// File: rtl/pss_pkg.sv
package pss_pkg;

  // Strobes from the control unit to the stage datapath
  typedef struct packed {
    logic shiftEn;     // edge moves the chain and takes the serial bit
    logic parCapture;  // edge copies the parallel word
    logic parFollow;   // stages are transparent to the parallel word
    logic useHeld;     // frozen parallel word stands in for the stages
  } pss_strobe_t;

endpackage

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
#(
  parameter int ASYNC_LOAD = 0
) (
  input  logic        clk,
  input  logic        loadSel,
  output pss_strobe_t strobes
);

  assign strobes.shiftEn    = ~loadSel;
  assign strobes.parCapture = loadSel;

  generate
    if (ASYNC_LOAD != 0) begin : g_async
      // Set at once by the mode; cleared by the first edge seen with the mode low
      logic pendingHold;
      always_ff @(posedge clk or posedge loadSel) begin
        if (loadSel) pendingHold <= 1'b1;
        else         pendingHold <= 1'b0;
      end
      assign strobes.parFollow = loadSel;
      assign strobes.useHeld   = pendingHold & ~loadSel;
    end else begin : g_sync
      assign strobes.parFollow = 1'b0;
      assign strobes.useHeld   = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/pss_datapath.sv
module pss_datapath
  import pss_pkg::*;
#(
  parameter int ASYNC_LOAD = 0,
  parameter int STAGES     = 8,
  parameter int TAPS       = 3
) (
  input  logic              clk,
  input  logic              serialIn,
  input  logic [STAGES-1:0] parallelIn,
  input  pss_strobe_t       strobes,
  output logic [TAPS-1:0]   taps
);

  localparam int TAP_LO = STAGES - TAPS;

  logic [STAGES-1:0] stageReg;
  logic [STAGES-1:0] heldPar;
  logic [STAGES-1:0] effState;

  generate
    if (ASYNC_LOAD != 0) begin : g_hold
      always_latch begin
        if (strobes.parFollow) heldPar = parallelIn;
      end
    end else begin : g_nohold
      assign heldPar = '0;
    end
  endgenerate

  // Visible content of the chain
  always_comb begin
    if (strobes.parFollow)    effState = parallelIn;
    else if (strobes.useHeld) effState = heldPar;
    else                      effState = stageReg;
  end

  always_ff @(posedge clk) begin
    if (strobes.parCapture)   stageReg <= parallelIn;
    else if (strobes.shiftEn) stageReg <= {effState[STAGES-2:0], serialIn};
  end

  generate
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
      assign taps[t] = effState[TAP_LO + t];
    end
  endgenerate

  // Checker arming: no reset, so wait two edges before trusting $past
  logic [1:0] armCnt = 2'd0;
  always_ff @(posedge clk) begin
    if (armCnt != 2'd2) armCnt <= armCnt + 2'd1;
  end
  logic armed;
  assign armed = (armCnt == 2'd2);

  // R2: the chain moves one place per edge
  p_shift_r2: assert property (@(posedge clk) disable iff (!armed)
    !strobes.parCapture |=> stageReg[STAGES-1:1] == $past(effState[STAGES-2:0]));

  // R2: stage 1 takes the serial bit
  p_serin_r2: assert property (@(posedge clk) disable iff (!armed)
    !strobes.parCapture |=> stageReg[0] == $past(serialIn));

  // R4: a load edge copies the parallel word
  p_load_r4: assert property (@(posedge clk) disable iff (!armed)
    strobes.parCapture |=> stageReg == $past(parallelIn));

  generate
    if (ASYNC_LOAD != 0) begin : g_hold_chk
      // R7: the edge after the mode falls shifts the frozen word
      p_held_r7: assert property (@(posedge clk) disable iff (!armed)
        strobes.useHeld |=> stageReg[STAGES-1:1] == $past(heldPar[STAGES-2:0]));
    end
  endgenerate

endmodule

// File: rtl/par_ser_shifter.sv
module par_ser_shifter
  import pss_pkg::*;
#(
  parameter int ASYNC_LOAD = 0,
  parameter int STAGES     = 8
) (
  input  logic              clk,
  input  logic              serialIn,
  input  logic              loadSel,
  input  logic [STAGES-1:0] parallelIn,
  output logic              tapStage6,
  output logic              tapStage7,
  output logic              tapStage8
);

  localparam int TAPS = 3;

  pss_strobe_t     strobes;
  logic [TAPS-1:0] taps;

  pss_ctrl #(.ASYNC_LOAD(ASYNC_LOAD)) u_ctrl (
    .clk     (clk),
    .loadSel (loadSel),
    .strobes (strobes)
  );

  pss_datapath #(.ASYNC_LOAD(ASYNC_LOAD), .STAGES(STAGES), .TAPS(TAPS)) u_dp (
    .clk        (clk),
    .serialIn   (serialIn),
    .parallelIn (parallelIn),
    .strobes    (strobes),
    .taps       (taps)
  );

  assign tapStage6 = taps[0];
  assign tapStage7 = taps[1];
  assign tapStage8 = taps[2];

endmodule

// File: tb/sim_par_ser_shifter.sv
`timescale 1ns/1ps
module sim_par_ser_shifter;

  logic       clk = 1'b0;
  logic       serIn = 1'b0;
  logic       loadSel = 1'b0;
  logic [7:0] parIn = 8'h00;

  logic s6, s7, s8;   // clocked-load version
  logic a6, a7, a8;   // transparent-load version

  logic [7:0] mSync, mAsync;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  par_ser_shifter #(.ASYNC_LOAD(0)) u0 (
    .clk(clk), .serialIn(serIn), .loadSel(loadSel), .parallelIn(parIn),
    .tapStage6(s6), .tapStage7(s7), .tapStage8(s8));

  par_ser_shifter #(.ASYNC_LOAD(1)) u1 (
    .clk(clk), .serialIn(serIn), .loadSel(loadSel), .parallelIn(parIn),
    .tapStage6(a6), .tapStage7(a7), .tapStage8(a8));

  task automatic check3(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic checkBoth(input string req);
    check3({req, " clocked"}, {s8, s7, s6}, mSync[7:5]);
    check3({req, " transparent"}, {a8, a7, a6}, mAsync[7:5]);
  endtask

  // Change inputs while the clock is low; transparent model follows at once
  task automatic drive(input logic sel, input logic [7:0] par, input logic ser);
    loadSel = sel;
    parIn = par;
    serIn = ser;
    if (sel) mAsync = par;
    #1;
  endtask

  // One 100 MHz clock period; models updated from the requirements
  task automatic tick();
    if (loadSel) mSync = parIn; else mSync = {mSync[6:0], serIn};
    if (loadSel) mAsync = parIn; else mAsync = {mAsync[6:0], serIn};
    #4 clk = 1'b1;
    #5 clk = 1'b0;
    #1;
  endtask

  // R1 / R4: parallel load and stage order as the word drains out
  task automatic t_load_order();
    drive(1'b1, 8'b0110_0101, 1'b1);
    tick();
    checkBoth("R4 load");
    drive(1'b0, 8'hFF, 1'b0);
    for (int k = 0; k < 7; k++) begin
      tick();
      checkBoth("R1 order");
    end
  endtask

  // R3 / R2: a single one walks through a zeroed chain
  task automatic t_serial_delay();
    drive(1'b0, 8'h00, 1'b0);
    for (int k = 0; k < 8; k++) tick();
    checkBoth("R2 zero fill");
    drive(1'b0, 8'h00, 1'b1);
    for (int k = 1; k <= 9; k++) begin
      tick();
      if (k == 1) drive(1'b0, 8'h00, 1'b0);
      check3("R3 delay clocked", {s8, s7, s6}, {k == 8, k == 7, k == 6});
      check3("R3 delay transparent", {a8, a7, a6}, {k == 8, k == 7, k == 6});
    end
  endtask

  // R4 / R5: serial input ignored on a load; clocked load waits, transparent follows
  task automatic t_load_styles();
    drive(1'b1, 8'h00, 1'b1);
    tick();
    checkBoth("R4 serial ignored");
    drive(1'b1, 8'hFF, 1'b0);
    check3("R4 no edge no load", {s8, s7, s6}, 3'b000);
    check3("R5 follow", {a8, a7, a6}, 3'b111);
    drive(1'b1, 8'h40, 1'b1);
    check3("R5 follow change", {a8, a7, a6}, 3'b010);
    check3("R4 still waiting", {s8, s7, s6}, 3'b000);
    tick();
    checkBoth("R4 edge load");
  endtask

  // R7: transparent version freezes the word when the mode falls
  task automatic t_async_hold();
    drive(1'b1, 8'hA0, 1'b0);
    check3("R5 follow A0", {a8, a7, a6}, 3'b101);
    drive(1'b0, 8'hA0, 1'b0);
    drive(1'b0, 8'h00, 1'b1);
    check3("R7 held after fall", {a8, a7, a6}, 3'b101);
    #50;
    check3("R7 held long", {a8, a7, a6}, 3'b101);
    drive(1'b0, 8'h00, 1'b0);
    tick();
    check3("R7 held word shifted", {a8, a7, a6}, 3'b010);
    checkBoth("R7 models");
  endtask

  // R6: stopped clock, busy inputs
  task automatic t_static();
    drive(1'b0, 8'h00, 1'b1);
    tick();
    drive(1'b0, 8'h00, 1'b0);
    tick();
    drive(1'b0, 8'h00, 1'b1);
    tick();
    checkBoth("R6 before stop");
    for (int k = 0; k < 20; k++) begin
      drive(1'b0, 8'(k * 37), k[0]);
      #40;
    end
    checkBoth("R6 after stop");
  endtask

  // R8: both versions match on shift edges
  task automatic t_equiv();
    logic [7:0] pat;
    pat = 8'hC5;
    for (int k = 0; k < 8; k++) begin
      drive(1'b0, 8'h3C, pat[k]);
      tick();
      check3("R8 styles agree", {a8, a7, a6}, {s8, s7, s6});
    end
    checkBoth("R8 models");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    mSync = 8'h00;
    mAsync = 8'h00;
    #3;
    t_load_order();
    t_serial_delay();
    t_load_styles();
    t_async_hold();
    t_static();
    t_equiv();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule